// File: doc/BRIEF.md
# Post-Write Emulation Dispatcher

This block runs once an operation that contained a virtualized register write has finished. It takes one request carrying the page offset that was written, the interrupt-delivery enable, and the current shadow copies of the task-priority and interrupt-command-low registers. From the offset it picks a single follow-up: trim the shadow task-priority register and signal a priority update; clear the shadow end-of-interrupt register and signal end-of-interrupt handling; post a self-interrupt; or raise a write-exit.

Every accepted request takes a fixed two-cycle path. In the first cycle the block drives at most one shadow-register write strobe with its data. In the second cycle it drives exactly one pulse: an action or the exit. The request handshake stays low over both cycles, so a new request waits until the block is idle again. The logic that arbitrates priorities and delivers interrupts sits downstream and is not part of this block.

Top module: `wr_emul_dispatch`

## Requirements
- R1: After reset, and whenever it is idle, the block has req_ready_o=1 and all write strobes, action pulses, exit_o, reg_wdata_o and self_vec_o at 0.
- R2: For offset 0x080, the cycle after acceptance has tpr_we_o=1 and reg_wdata_o equal to the sampled task-priority value with bits 31:8 zeroed. act_prio_o pulses in the next cycle. The delivery enable has no effect on this path.
- R3: For offset 0x0B0 with the delivery enable at 1, the cycle after acceptance has eoi_we_o=1 and reg_wdata_o=0. act_eoi_o pulses in the next cycle.
- R4: For offset 0x0B0 with the delivery enable at 0, no strobe is driven and exit_o pulses in the second cycle.
- R5: For offset 0x300 with the delivery enable at 1, the command word is valid when all of these hold: bits 31:20, 17:16, 15, 13, 12 and 10:8 are 0; bits 19:18 are 2'b01; bits 7:4 are not 0. Bits 14, 11 and 3:0 are not examined. A valid word drives no strobe, and act_self_o pulses in the second cycle with self_vec_o equal to command bits 7:0.
- R6: For offset 0x300 with the delivery enable at 1, a command word that fails any condition in R5 makes exit_o pulse in the second cycle, with no strobe.
- R7: For offset 0x300 with the delivery enable at 0, exit_o pulses in the second cycle whatever the command word is.
- R8: Every offset other than 0x080, 0x0B0 and 0x300 makes exit_o pulse in the second cycle, with no strobe.
- R9: Each accepted request gives exactly one of act_prio_o, act_eoi_o, act_self_o and exit_o, for one cycle, two cycles after acceptance. Strobes appear only in the first cycle.
- R10: req_ready_o is 0 for the two cycles after acceptance. A request held valid over that time is neither accepted nor able to change the outputs. It is accepted once the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Emulation request |
| req_ready_o | output | 1 | Block idle, request accepted on this edge |
| req_off_i | input | 12 | Page offset of the virtualized write |
| dlv_en_i | input | 1 | Virtual interrupt delivery enable |
| tpr_val_i | input | 32 | Current shadow task-priority value |
| icr_val_i | input | 32 | Current shadow command-low value |
| tpr_we_o | output | 1 | Shadow task-priority write strobe |
| eoi_we_o | output | 1 | Shadow end-of-interrupt write strobe |
| reg_wdata_o | output | 32 | Data for the active write strobe |
| act_prio_o | output | 1 | Priority update action pulse |
| act_eoi_o | output | 1 | End-of-interrupt action pulse |
| act_self_o | output | 1 | Self-interrupt action pulse |
| self_vec_o | output | 8 | Vector posted with act_self_o |
| exit_o | output | 1 | Write-exit pulse |

## Verification
The assertions assume that the offset, enable and shadow inputs are steady at the edge where a request is accepted. They also assume that, after acceptance, the task-priority input does not change before the strobe cycle, because the data check compares against the value from the previous cycle. The bench drives every input on the falling edge and holds it across the accepting edge. It changes the inputs only after the strobe cycle, except in the stall test. There they are changed while req_ready_o is low, and the check looks only at the outputs of the first request and at the later acceptance of the second.

// File: rtl/wr_emul_pkg.sv
package wr_emul_pkg;
  localparam int OFF_W  = 12;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;

  localparam logic [OFF_W-1:0] OFF_TPR = 12'h080;
  localparam logic [OFF_W-1:0] OFF_EOI = 12'h0B0;
  localparam logic [OFF_W-1:0] OFF_ICR = 12'h300;

  localparam logic [DATA_W-1:0] TPR_KEEP = 32'h0000_00FF;
  // fields that must hold a fixed value in a self command: zeros + shorthand
  localparam logic [DATA_W-1:0] ICR_FIX_MASK = 32'hFFFF_B700;
  localparam logic [DATA_W-1:0] ICR_FIX_VAL  = 32'h0004_0000;

  typedef enum logic [1:0] {K_TPR, K_EOI, K_SELF, K_EXIT} kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WR, ST_ACT} st_e;
endpackage

// File: rtl/wr_emul_cmd_check.sv
module wr_emul_cmd_check
  import wr_emul_pkg::*;
(
  input  logic [DATA_W-1:0] icr_i,
  output logic              ok_o
);
  logic fix_ok, vec_ok;
  assign fix_ok = (icr_i & ICR_FIX_MASK) == ICR_FIX_VAL;
  assign vec_ok = |icr_i[7:4];
  assign ok_o   = fix_ok & vec_ok;
endmodule

// File: rtl/wr_emul_classify.sv
module wr_emul_classify
  import wr_emul_pkg::*;
(
  input  logic [OFF_W-1:0] off_i,
  input  logic             dlv_en_i,
  input  logic             cmd_ok_i,
  output kind_e            kind_o
);
  always_comb begin
    kind_o = K_EXIT;
    if (off_i == OFF_TPR)                             kind_o = K_TPR;
    else if (off_i == OFF_EOI && dlv_en_i)            kind_o = K_EOI;
    else if (off_i == OFF_ICR && dlv_en_i && cmd_ok_i) kind_o = K_SELF;
  end
endmodule

// File: rtl/wr_emul_seq.sv
module wr_emul_seq
  import wr_emul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  kind_e             kind_i,
  input  logic [DATA_W-1:0] tpr_val_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              tpr_we_o,
  output logic              eoi_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              act_prio_o,
  output logic              act_eoi_o,
  output logic              act_self_o,
  output logic [VEC_W-1:0]  self_vec_o,
  output logic              exit_o
);
  st_e               st_q;
  kind_e             kind_q;
  logic [DATA_W-1:0] wdata_q;
  logic [VEC_W-1:0]  vec_q;
  logic              accept;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_EXIT;
      wdata_q <= '0;
      vec_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_WR;
          kind_q  <= kind_i;
          wdata_q <= (kind_i == K_TPR) ? (tpr_val_i & TPR_KEEP) : '0;
          vec_q   <= (kind_i == K_SELF) ? vec_i : '0;
        end
        ST_WR:   st_q <= ST_ACT;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic in_wr, in_act;
  assign in_wr  = (st_q == ST_WR);
  assign in_act = (st_q == ST_ACT);

  assign tpr_we_o    = in_wr & (kind_q == K_TPR);
  assign eoi_we_o    = in_wr & (kind_q == K_EOI);
  assign reg_wdata_o = in_wr ? wdata_q : '0;
  assign act_prio_o  = in_act & (kind_q == K_TPR);
  assign act_eoi_o   = in_act & (kind_q == K_EOI);
  assign act_self_o  = in_act & (kind_q == K_SELF);
  assign exit_o      = in_act & (kind_q == K_EXIT);
  assign self_vec_o  = act_self_o ? vec_q : '0;

  // R10
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R9
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_prio_o, act_eoi_o, act_self_o, exit_o}));
  // R9
  result_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 ($countones({act_prio_o, act_eoi_o, act_self_o, exit_o}) == 1));
  // R2
  prio_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_o |=> act_prio_o);
  // R2
  tpr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpr_we_o |-> (reg_wdata_o == ($past(tpr_val_i) & TPR_KEEP)));
  // R3
  eoi_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_we_o |=> act_eoi_o);
  // R3
  eoi_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_we_o |-> reg_wdata_o == '0);
  // R5
  self_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_self_o |-> self_vec_o[7:4] != 4'h0);
endmodule

// File: rtl/wr_emul_dispatch.sv
module wr_emul_dispatch
  import wr_emul_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic              dlv_en_i,
  input  logic [DATA_W-1:0] tpr_val_i,
  input  logic [DATA_W-1:0] icr_val_i,
  output logic              tpr_we_o,
  output logic              eoi_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              act_prio_o,
  output logic              act_eoi_o,
  output logic              act_self_o,
  output logic [VEC_W-1:0]  self_vec_o,
  output logic              exit_o
);
  logic  cmd_ok;
  kind_e kind;

  wr_emul_cmd_check u_chk (
    .icr_i (icr_val_i),
    .ok_o  (cmd_ok)
  );

  wr_emul_classify u_cls (
    .off_i    (req_off_i),
    .dlv_en_i (dlv_en_i),
    .cmd_ok_i (cmd_ok),
    .kind_o   (kind)
  );

  wr_emul_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .kind_i      (kind),
    .tpr_val_i   (tpr_val_i),
    .vec_i       (icr_val_i[VEC_W-1:0]),
    .tpr_we_o    (tpr_we_o),
    .eoi_we_o    (eoi_we_o),
    .reg_wdata_o (reg_wdata_o),
    .act_prio_o  (act_prio_o),
    .act_eoi_o   (act_eoi_o),
    .act_self_o  (act_self_o),
    .self_vec_o  (self_vec_o),
    .exit_o      (exit_o)
  );

  // R7
  self_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !dlv_en_i) |=> ##1 !act_self_o && !act_eoi_o);
  // R8
  foreign_off_exits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_off_i != OFF_TPR && req_off_i != OFF_EOI
     && req_off_i != OFF_ICR) |=> ##1 exit_o);
  // R4
  eoi_off_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_off_i == OFF_EOI && !dlv_en_i) |=> !eoi_we_o ##1 exit_o);
endmodule

// File: tb/wr_emul_dispatch_test.sv
`timescale 1ns/1ps
module wr_emul_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_off = '0;
  logic        dlv_en = 1'b0;
  logic [31:0] tpr_val = '0;
  logic [31:0] icr_val = '0;
  logic        tpr_we, eoi_we, act_prio, act_eoi, act_self, exit_p;
  logic [31:0] reg_wdata;
  logic [7:0]  self_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wr_emul_dispatch uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_off_i(req_off), .dlv_en_i(dlv_en), .tpr_val_i(tpr_val), .icr_val_i(icr_val),
    .tpr_we_o(tpr_we), .eoi_we_o(eoi_we), .reg_wdata_o(reg_wdata),
    .act_prio_o(act_prio), .act_eoi_o(act_eoi), .act_self_o(act_self),
    .self_vec_o(self_vec), .exit_o(exit_p)
  );

  // we: 0 none, 1 tpr, 2 eoi; act: 0 prio, 1 eoi, 2 self, 3 exit
  typedef struct packed {
    logic [3:0]  rq;
    logic [11:0] off;
    logic        en;
    logic [31:0] tpr;
    logic [31:0] icr;
    logic [1:0]  we;
    logic [31:0] wd;
    logic [1:0]  act;
    logic [7:0]  vec;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  12'h080, 1'b1, 32'hA5B6C7D8, 32'h0,         2'd1, 32'h000000D8, 2'd0, 8'h00}, // R2
    '{4'd2,  12'h080, 1'b0, 32'h12345678, 32'h0,         2'd1, 32'h00000078, 2'd0, 8'h00}, // R2
    '{4'd3,  12'h0B0, 1'b1, 32'hFFFFFFFF, 32'h0,         2'd2, 32'h00000000, 2'd1, 8'h00}, // R3
    '{4'd4,  12'h0B0, 1'b0, 32'h0,        32'h0,         2'd0, 32'h00000000, 2'd3, 8'h00}, // R4
    '{4'd5,  12'h300, 1'b1, 32'h0,        32'h00040031,  2'd0, 32'h00000000, 2'd2, 8'h31}, // R5
    '{4'd5,  12'h300, 1'b1, 32'h0,        32'h000448F2,  2'd0, 32'h00000000, 2'd2, 8'hF2}, // R5
    '{4'd5,  12'h300, 1'b1, 32'h0,        32'h000400FF,  2'd0, 32'h00000000, 2'd2, 8'hFF}, // R5
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h0004000F,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h00000031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h000C0031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h00040131,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h00048031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h00041031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h00042031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h00060031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd6,  12'h300, 1'b1, 32'h0,        32'h80040031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R6
    '{4'd7,  12'h300, 1'b0, 32'h0,        32'h00040031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R7
    '{4'd8,  12'h020, 1'b1, 32'hFF,       32'h00040031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R8
    '{4'd8,  12'h310, 1'b1, 32'h0,        32'h00040031,  2'd0, 32'h00000000, 2'd3, 8'h00}, // R8
    '{4'd8,  12'h081, 1'b1, 32'hFF,       32'h0,         2'd0, 32'h00000000, 2'd3, 8'h00}, // R8
    '{4'd8,  12'h3E0, 1'b1, 32'h0,        32'h0,         2'd0, 32'h00000000, 2'd3, 8'h00}  // R8
  };

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: got=%h exp=%h", rq, what, got, exp);
    end
  endtask

  function automatic logic [3:0] res_bits();
    return {exit_p, act_self, act_eoi, act_prio};
  endfunction

  task automatic chk_idle(input int rq, input string what);
    chk(req_ready == 1'b1, rq, {what, " ready"}, 32'(req_ready), 32'd1);
    chk({tpr_we, eoi_we, res_bits()} == 6'b0 && reg_wdata == '0 && self_vec == '0,
        rq, {what, " quiet"}, {20'h0, tpr_we, eoi_we, res_bits(), self_vec[5:0]}, 32'h0);
  endtask

  // called just after a falling edge
  task automatic run_req(input vec_t v);
    req_off = v.off; dlv_en = v.en; tpr_val = v.tpr; icr_val = v.icr;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, 10, "busy in strobe cycle", 32'(req_ready), 32'd0);
    chk({eoi_we, tpr_we} == v.we, int'(v.rq), "strobe", {30'h0, eoi_we, tpr_we}, {30'h0, v.we});
    chk(reg_wdata == v.wd, int'(v.rq), "wdata", reg_wdata, v.wd);
    chk(res_bits() == 4'b0, 9, "no early result", {28'h0, res_bits()}, 32'h0);
    @(negedge clk);
    chk(res_bits() == (4'b0001 << v.act), int'(v.rq), "result",
        {28'h0, res_bits()}, {28'h0, 4'b0001 << v.act});
    chk({tpr_we, eoi_we} == 2'b0, 9, "strobe only once", {30'h0, tpr_we, eoi_we}, 32'h0);
    chk(self_vec == v.vec, int'(v.rq), "vector", {24'h0, self_vec}, {24'h0, v.vec});
    @(negedge clk);
    chk_idle(1, "back to idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_idle(1, "in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk_idle(1, "after reset");

    for (int i = 0; i < NV; i++) run_req(TBL[i]);

    // R10 request held valid while busy, inputs changed under stall
    req_off = 12'h080; dlv_en = 1'b1; tpr_val = 32'h0000_0044; icr_val = '0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_off = 12'h300; icr_val = 32'h0004_0057; tpr_val = 32'hFFFF_FFFF;
    chk(req_ready == 1'b0, 10, "stall ready", 32'(req_ready), 32'd0);
    chk(tpr_we == 1'b1 && reg_wdata == 32'h44, 10, "stall keeps first data", reg_wdata, 32'h44);
    @(negedge clk);
    chk(res_bits() == 4'b0001, 10, "stall keeps first result", {28'h0, res_bits()}, 32'h1);
    @(negedge clk);
    chk(req_ready == 1'b1 && res_bits() == 4'b0, 10, "idle gap after result",
        {27'h0, req_ready, res_bits()}, 32'h10);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0 && tpr_we == 1'b0, 10, "held request accepted",
        {30'h0, req_ready, tpr_we}, 32'h0);
    @(negedge clk);
    chk(act_self == 1'b1 && self_vec == 8'h57, 10, "held request result",
        {23'h0, act_self, self_vec}, 32'h157);
    @(negedge clk);
    chk_idle(1, "after stall test");

    // R1 reset while busy
    req_off = 12'h0B0; dlv_en = 1'b1; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk_idle(1, "reset mid request");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_idle(1, "no result after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule